// File: doc/BRIEF.md
# Serial Presence Memory Write-Protect Controller

This block sits between a two-wire serial slave and a 256-byte nonvolatile data array. Every write request from the slave passes through a protection gate before it may touch the array. The lower 128 bytes can be locked by two independent flags. One flag is permanent: once it is set, only a full power-on reset of the model clears it. The other flag is reversible: software can set it and clear it at will. The upper 128 bytes are always writable. A write that the gate blocks leaves the array unchanged and raises a reject pulse, which the bus side turns into a NACK.

Write requests arrive on a valid/ready stream. A request is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while either reset is asserted and goes high on the first clock edge after both resets are released. While `wr_ready` is low, a held request is neither taken nor lost; the master keeps it pending. The block takes at most one request per cycle.

Protection commands, read accesses and status outputs are plain control pins. The array is modelled as a register array. Reads are never gated.

Top module: `spd_wp_ctrl`

## Requirements
- R1: A write accepted at an address in the upper half (80h to FFh) is always stored. In the cycle after acceptance, `arr_we` pulses high for one cycle, with `arr_addr` and `arr_wdata` showing the request, and `wr_reject` stays low.
- R2: A write accepted at an address in the lower half (00h to 7Fh) while either protection flag is set is not stored. In the cycle after acceptance, `wr_reject` pulses high for one cycle and `arr_we` stays low. The addressed byte keeps its old value.
- R3: A write accepted at a lower-half address while both flags are clear is stored and reported as in R1.
- R4: Command code 0 sets the permanent flag `prot_perm` on the next edge. After that, neither command code 2 nor the soft reset `rst_n` clears it. Only `por_n` low clears it.
- R5: Command code 1 sets the reversible flag `prot_rev` and command code 2 clears it. Each takes effect on the edge that takes the command.
- R6: Command code 0 issued while `prot_perm` is already set raises a one-cycle `cmd_reject` pulse in the following cycle. No other command is ever rejected.
- R7: Command code 3 (status query) pulses `stat_valid` in the following cycle. In that cycle, `stat_bits` bit 1 holds the permanent flag and bit 0 holds the reversible flag, both as they were before that edge.
- R8: `rd_en` high at an edge loads `rd_data` with the byte at `rd_addr`. The new value is visible in the following cycle, whatever the protection state. A read and a write to the same byte in the same cycle return the old byte.
- R9: The soft reset `rst_n` clears the reversible flag. It leaves the array contents and the permanent flag unchanged.
- R10: `wr_ready` is low while either reset is asserted. A request presented while `wr_ready` is low does not reach the array.
- R11: A write and a command taken on the same edge are handled in a fixed order: the write is judged against the flags as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears both flags |
| rst_n | input | 1 | Soft reset, active low, asynchronous; clears the reversible flag only |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request may be taken |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write byte |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_op | input | 2 | 0 set permanent, 1 set reversible, 2 clear reversible, 3 query |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte, registered |
| arr_we | output | 1 | Gated write strobe as applied to the array, one cycle after acceptance |
| arr_addr | output | 8 | Address of the stored write |
| arr_wdata | output | 8 | Data of the stored write |
| wr_reject | output | 1 | Write suppressed by protection, for the bus side to NACK |
| cmd_reject | output | 1 | Command refused |
| stat_valid | output | 1 | Status query answer valid |
| stat_bits | output | 2 | Bit 1 permanent flag, bit 0 reversible flag |
| prot_perm | output | 1 | Permanent flag, live |
| prot_rev | output | 1 | Reversible flag, live |

## Verification
Every result of this block lands exactly one clock edge after the edge that takes its stimulus:
- write outcome pulses (`arr_we`, `wr_reject`),
- command reject and status answer,
- read data,
- flag changes.

The bench drives stimulus on the falling edge and samples on the next falling edge. That puts every sample exactly one rising edge after the stimulus and between edges. A rejected write is confirmed through a later read of the same byte.

The asynchronous resets act at once on `wr_ready` and on the flags. Those are checked a nanosecond after the reset pin changes. A held request that the reset blocked is confirmed by reading the target byte back after release.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;

  typedef enum logic [1:0] {
    OP_SET_PERM = 2'd0,
    OP_SET_REV  = 2'd1,
    OP_CLR_REV  = 2'd2,
    OP_QUERY    = 2'd3
  } wp_op_e;

  typedef struct packed {
    logic perm;
    logic rev;
  } wp_flags_t;

endpackage

// File: rtl/spd_wp_flags.sv
module spd_wp_flags
  import spd_wp_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       soft_rst_n,
  input  logic       cmd_fire,
  input  wp_op_e     cmd_op,
  output wp_flags_t  flags,
  output logic       cmd_rej_q,
  output logic       stat_valid_q,
  output wp_flags_t  stat_q
);

  logic perm_q;
  logic rev_q;

  // Permanent flag: only the power-on reset reaches it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      perm_q <= 1'b0;
    end else if (cmd_fire && cmd_op == OP_SET_PERM) begin
      perm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      rev_q <= 1'b0;
    end else if (cmd_fire && cmd_op == OP_SET_REV) begin
      rev_q <= 1'b1;
    end else if (cmd_fire && cmd_op == OP_CLR_REV) begin
      rev_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      cmd_rej_q    <= 1'b0;
      stat_valid_q <= 1'b0;
      stat_q       <= '0;
    end else begin
      cmd_rej_q    <= cmd_fire && cmd_op == OP_SET_PERM && perm_q;
      stat_valid_q <= cmd_fire && cmd_op == OP_QUERY;
      if (cmd_fire && cmd_op == OP_QUERY) begin
        stat_q <= '{perm: perm_q, rev: rev_q};
      end
    end
  end

  assign flags = '{perm: perm_q, rev: rev_q};

  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    perm_q |=> perm_q); // R4

  AST_REV_CLEARS: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (cmd_fire && cmd_op == OP_CLR_REV) |=> !rev_q); // R5

  AST_REV_SETS: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (cmd_fire && cmd_op == OP_SET_REV) |=> rev_q); // R5

  AST_ONLY_PERM_REJ: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (cmd_fire && cmd_op != OP_SET_PERM) |=> !cmd_rej_q); // R6

endmodule

// File: rtl/spd_wp_gate.sv
module spd_wp_gate
  import spd_wp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          fire,
  input  logic [AW-1:0] addr,
  input  wp_flags_t     flags,
  output logic          we,
  output logic          rej
);

  localparam int HALF = 1 << (AW - 1);

  logic lower;
  logic locked;

  assign lower  = int'(addr) < HALF;
  assign locked = lower && (flags.perm || flags.rev);
  assign we     = fire && !locked;
  assign rej    = fire && locked;

endmodule

// File: rtl/spd_wp_mem.sv
module spd_wp_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          soft_rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // Contents model nonvolatile storage: no reset reaches them.
  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= cells[raddr];
    end
  end

endmodule

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl
  import spd_wp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  output logic          wr_reject,
  output logic          cmd_reject,
  output logic          stat_valid,
  output logic [1:0]    stat_bits,
  output logic          prot_perm,
  output logic          prot_rev
);

  logic      soft_rst_n;
  logic      ready_q;
  logic      fire;
  logic      gate_we;
  logic      gate_rej;
  wp_flags_t flags;
  wp_flags_t stat_q;

  assign soft_rst_n = por_n & rst_n;
  assign fire       = wr_valid && ready_q;

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
    end
  end

  spd_wp_flags u_flags (
    .clk          (clk),
    .por_n        (por_n),
    .soft_rst_n   (soft_rst_n),
    .cmd_fire     (cmd_valid && soft_rst_n),
    .cmd_op       (wp_op_e'(cmd_op)),
    .flags        (flags),
    .cmd_rej_q    (cmd_reject),
    .stat_valid_q (stat_valid),
    .stat_q       (stat_q)
  );

  spd_wp_gate #(.AW(AW)) u_gate (
    .fire  (fire),
    .addr  (wr_addr),
    .flags (flags),
    .we    (gate_we),
    .rej   (gate_rej)
  );

  spd_wp_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk        (clk),
    .soft_rst_n (soft_rst_n),
    .we         (gate_we),
    .waddr      (wr_addr),
    .wdata      (wr_data),
    .rd_en      (rd_en),
    .raddr      (rd_addr),
    .rdata      (rd_data)
  );

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      arr_we    <= 1'b0;
      wr_reject <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we    <= gate_we;
      wr_reject <= gate_rej;
      if (gate_we) begin
        arr_addr  <= wr_addr;
        arr_wdata <= wr_data;
      end
    end
  end

  assign wr_ready  = ready_q;
  assign stat_bits = stat_q;
  assign prot_perm = flags.perm;
  assign prot_rev  = flags.rev;

  AST_UPPER_OPEN: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (wr_valid && wr_ready && wr_addr[AW-1]) |=> (arr_we && !wr_reject)); // R1

  AST_LOWER_LOCKED: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (wr_valid && wr_ready && !wr_addr[AW-1] && (prot_perm || prot_rev))
      |=> (wr_reject && !arr_we)); // R2

  AST_LOWER_OPEN: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (wr_valid && wr_ready && !wr_addr[AW-1] && !prot_perm && !prot_rev)
      |=> arr_we); // R3

  AST_NO_WRITE_UNREADY: assert property (@(posedge clk) disable iff (!soft_rst_n)
    (!wr_valid || !wr_ready) |=> (!arr_we && !wr_reject)); // R10

endmodule

// File: tb/spd_wp_ctrl_bench.sv
`timescale 1ns/1ps
module spd_wp_ctrl_bench;

  logic       clk = 1'b0;
  logic       por_n, rst_n;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_addr, wr_data;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic       rd_en;
  logic [7:0] rd_addr, rd_data;
  logic       arr_we, wr_reject, cmd_reject, stat_valid, prot_perm, prot_rev;
  logic [7:0] arr_addr, arr_wdata;
  logic [1:0] stat_bits;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  spd_wp_ctrl u_spd_wp_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .wr_reject(wr_reject), .cmd_reject(cmd_reject),
    .stat_valid(stat_valid), .stat_bits(stat_bits),
    .prot_perm(prot_perm), .prot_rev(prot_rev)
  );

  // kind[25:24] 0 write, 1 command, 2 read; addr; data or opcode; expected
  localparam int NV = 25;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 8'h10, 8'hA5, 8'h00}, {2'd2, 8'h10, 8'h00, 8'hA5},
    {2'd0, 8'h90, 8'h3C, 8'h00}, {2'd1, 8'h00, 8'h01, 8'h00},
    {2'd1, 8'h00, 8'h03, 8'h01}, {2'd0, 8'h10, 8'h77, 8'h01},
    {2'd2, 8'h10, 8'h00, 8'hA5}, {2'd0, 8'h7F, 8'h11, 8'h01},
    {2'd0, 8'h80, 8'h22, 8'h00}, {2'd2, 8'h80, 8'h00, 8'h22},
    {2'd1, 8'h00, 8'h02, 8'h00}, {2'd1, 8'h00, 8'h03, 8'h00},
    {2'd0, 8'h7F, 8'h11, 8'h00}, {2'd2, 8'h7F, 8'h00, 8'h11},
    {2'd1, 8'h00, 8'h00, 8'h00}, {2'd1, 8'h00, 8'h03, 8'h02},
    {2'd1, 8'h00, 8'h00, 8'h01}, {2'd1, 8'h00, 8'h02, 8'h00},
    {2'd1, 8'h00, 8'h03, 8'h02}, {2'd0, 8'h10, 8'h55, 8'h01},
    {2'd2, 8'h10, 8'h00, 8'hA5}, {2'd0, 8'hFF, 8'h99, 8'h00},
    {2'd2, 8'hFF, 8'h00, 8'h99}, {2'd1, 8'h00, 8'h01, 8'h00},
    {2'd1, 8'h00, 8'h03, 8'h03}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid = 0; cmd_valid = 0; rd_en = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    step();
    idle();
  endtask

  task automatic do_read(input logic [7:0] a);
    rd_en = 1; rd_addr = a;
    step();
    idle();
  endtask

  task automatic do_cmd(input logic [1:0] op);
    cmd_valid = 1; cmd_op = op;
    step();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    por_n = 0; rst_n = 0; idle();
    wr_addr = 0; wr_data = 0; cmd_op = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    chk(!wr_ready, "R10 ready in reset", wr_ready, 0);
    chk(!prot_perm && !prot_rev, "R4 flags at reset", {prot_perm, prot_rev}, 0);
    chk(!arr_we && !wr_reject && !cmd_reject && !stat_valid, "R1 idle outputs at reset",
        {arr_we, wr_reject, cmd_reject, stat_valid}, 0);
    por_n = 1; rst_n = 1;
    step();
    chk(wr_ready, "R10 ready after reset", wr_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      logic [7:0] a, d, e;
      {k, a, d, e} = VEC[i];
      if (k == 2'd0) begin
        do_write(a, d);
        if (e[0])
          chk(wr_reject && !arr_we, "R2 write locked", {arr_we, wr_reject}, 1);
        else if (a[7])
          chk(arr_we && !wr_reject && arr_addr == a && arr_wdata == d, "R1 upper write",
              {arr_we, wr_reject, arr_wdata}, {2'b10, d});
        else
          chk(arr_we && !wr_reject && arr_addr == a && arr_wdata == d, "R3 lower write",
              {arr_we, wr_reject, arr_wdata}, {2'b10, d});
      end else if (k == 2'd2) begin
        do_read(a);
        chk(rd_data == e, "R8 read", rd_data, e);
      end else if (d[1:0] == 2'd3) begin
        do_cmd(d[1:0]);
        chk(stat_valid && stat_bits == e[1:0], "R7 status", {stat_valid, stat_bits}, {1'b1, e[1:0]});
      end else if (d[1:0] == 2'd0) begin
        do_cmd(d[1:0]);
        if (e[0]) chk(cmd_reject, "R6 repeat permanent", cmd_reject, 1);
        else      chk(!cmd_reject && prot_perm, "R4 set permanent", {cmd_reject, prot_perm}, 1);
      end else begin
        do_cmd(d[1:0]);
        chk(!cmd_reject && prot_rev == (d[1:0] == 2'd1 || prot_perm && prot_rev),
            "R5 reversible cmd", {cmd_reject, prot_rev}, e);
      end
    end

    // Soft reset with a request held while not ready
    rst_n = 0; wr_valid = 1; wr_addr = 8'h90; wr_data = 8'hEE;
    #1;
    chk(!wr_ready, "R10 ready drops in soft reset", wr_ready, 0);
    step();
    chk(prot_perm, "R4 permanent survives soft reset", prot_perm, 1);
    chk(!prot_rev, "R9 soft reset clears reversible", prot_rev, 0);
    rst_n = 1; idle();
    step();
    do_read(8'h90);
    chk(rd_data == 8'h3C, "R10 held request not stored", rd_data, 8'h3C);
    do_read(8'h10);
    chk(rd_data == 8'hA5, "R9 array kept over soft reset", rd_data, 8'hA5);
    do_write(8'h20, 8'h01);
    chk(wr_reject, "R4 lower still locked after soft reset", wr_reject, 1);

    // Power-on reset clears the permanent flag
    por_n = 0;
    #1;
    chk(!prot_perm, "R4 power-on clears permanent", prot_perm, 0);
    @(negedge clk);
    por_n = 1;
    step();
    do_write(8'h10, 8'h66);
    chk(arr_we && !wr_reject, "R4 lower writable after power-on", {arr_we, wr_reject}, 2);
    do_read(8'h10);
    chk(rd_data == 8'h66, "R3 lower byte stored", rd_data, 8'h66);

    // Read and write of one byte on the same edge
    wr_valid = 1; wr_addr = 8'hFF; wr_data = 8'h42; rd_en = 1; rd_addr = 8'hFF;
    step(); idle();
    chk(rd_data == 8'h99, "R8 read before write", rd_data, 8'h99);

    // Command and write on the same edge
    wr_valid = 1; wr_addr = 8'h20; wr_data = 8'h5A; cmd_valid = 1; cmd_op = 2'd1;
    step(); idle();
    chk(arr_we && !wr_reject, "R11 write judged on old flags", {arr_we, wr_reject}, 2);
    chk(prot_rev, "R11 command applied", prot_rev, 1);
    do_write(8'h20, 8'h00);
    chk(wr_reject, "R11 next write locked", wr_reject, 1);
    do_read(8'h20);
    chk(rd_data == 8'h5A, "R2 locked byte unchanged", rd_data, 8'h5A);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule